// File: doc/BRIEF.md
# Device Error Control and Status Registers

This block holds the device-level error reporting controls and the matching error status word of a PCI Express style bridge function. Error sources elsewhere in the bridge present one-cycle pulses for correctable, non-fatal and fatal errors and for unsupported requests. The block records each class in a sticky status bit that software clears by writing a one. In parallel it raises a one-cycle message request for a class, but only when software has enabled reporting of that class and the advanced error logic does not mask it. The status bit records the event whether or not a message goes out.

The block also counts non-posted requests that the bridge has issued and whose completions have not yet come back. The status word shows a transactions-pending flag while that count is non-zero. A small tracker state machine guards the count. It has three states. PEND_IDLE means nothing is outstanding. PEND_BUSY means some requests are outstanding and the count is below its ceiling. PEND_FULL means the count sits at its ceiling. The transitions are as follows:
- PEND_IDLE goes to PEND_BUSY on an issue without a completion.
- PEND_BUSY goes to PEND_IDLE on a completion without an issue when one request is left.
- PEND_BUSY goes to PEND_FULL on an issue without a completion when one step below the ceiling.
- PEND_FULL goes to PEND_BUSY on a completion without an issue.
- Every other input combination holds the state.

Software reaches both registers through a simple 16-bit port. The port has a byte address, two byte enables, write data and a combinational read-data output. The control word sits at byte offset 4Ch and the status word at 4Eh. The address is decoded per 16-bit word, so bit 0 of the address is ignored.

Top module: `dev_err_regs`

## Requirements
- R1: After reset, both the control word (4Ch) and the status word (4Eh) read 0000h.
- R2: Status bits 15:6 and bit 4 always read 0, and control bits 15:3 always read 0. Writes to those bits, and writes to any address outside the two words, change no readable state.
- R3: Status bit 5 reads 1 exactly when the outstanding non-posted count is non-zero. It follows the count from the first cycle after the clock edge that samples the issue or completion strobe.
- R4: The outstanding count is 6 bits wide and saturates at 63, so an issue at 63 is dropped. An issue and a completion in the same cycle leave the count unchanged. A completion while the count is zero is ignored.
- R5: An err_corr, err_nonfatal or err_fatal pulse sets status bit 0, 1 or 2 respectively at the next clock edge, whatever the enable and mask settings are.
- R6: A ur_event pulse sets status bit 3 at the next edge, unless ur_fwd is high in the same cycle. ur_fwd marks a request that was forwarded downstream and came back with unsupported-request status.
- R7: A write to the status word with reg_be[0]=1 clears each of bits 3:0 whose write-data bit is 1. A 0 leaves that bit as it is. With reg_be[0]=0, nothing is cleared.
- R8: When a set event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Control bits 0 (correctable enable), 1 (non-fatal enable) and 2 (fatal enable) are read/write. They are written only when reg_be[0]=1. Control bit 3 (unsupported-request enable) reads 0.
- R10: msg_corr, msg_nonfatal and msg_fatal pulse high for the one cycle after an edge that sampled the matching error pulse. This happens only if, at that edge, the class's enable was 1 and its mask input was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register access |
| reg_be | input | 2 | Byte enables, bit 0 for data bits 7:0 |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| err_corr | input | 1 | Correctable error pulse |
| err_nonfatal | input | 1 | Non-fatal error pulse |
| err_fatal | input | 1 | Fatal error pulse |
| ur_event | input | 1 | Unsupported request received pulse |
| ur_fwd | input | 1 | Qualifies ur_event as a forwarded request returned with unsupported status |
| mask_corr | input | 1 | Message mask for correctable errors |
| mask_nonfatal | input | 1 | Message mask for non-fatal errors |
| mask_fatal | input | 1 | Message mask for fatal errors |
| np_issue | input | 1 | Non-posted request issued |
| np_cpl | input | 1 | Completion received for a non-posted request |
| msg_corr | output | 1 | Correctable error message request |
| msg_nonfatal | output | 1 | Non-fatal error message request |
| msg_fatal | output | 1 | Fatal error message request |

## Verification
The hardest condition to reach from the ports is the saturated count. The tracker must sit in PEND_FULL and then drain. The only visible sign that the ceiling held is that the pending flag drops on exactly the 63rd completion after more than 63 issues. A directed run pushes 70 issues and then retires completions one by one, with the flag checked after each one. The collision of a set event with a write-one-to-clear on the same bit is also unlikely under random stimulus, so directed cycles create it. Seeded random traffic then mixes error pulses, masks, register writes and strobes against a bench model.

// File: rtl/dev_err_pkg.sv
package dev_err_pkg;

    localparam int REG_W    = 16;
    localparam int ADDR_W   = 8;
    localparam int NUM_CLS  = 3;   // correctable, non-fatal, fatal
    localparam int NUM_STAT = 4;   // the three classes plus unsupported request

    localparam logic [ADDR_W-1:0] CTRL_OFS = 8'h4C;
    localparam logic [ADDR_W-1:0] STAT_OFS = 8'h4E;

    // status word bit positions (software decodes these)
    localparam int STAT_CE_BIT   = 0;
    localparam int STAT_NF_BIT   = 1;
    localparam int STAT_FE_BIT   = 2;
    localparam int STAT_UR_BIT   = 3;
    localparam int STAT_AUX_BIT  = 4;
    localparam int STAT_PEND_BIT = 5;

    typedef enum logic [1:0] {
        PEND_IDLE = 2'd0,
        PEND_BUSY = 2'd1,
        PEND_FULL = 2'd2
    } pend_state_t;

    typedef logic [NUM_CLS-1:0]  cls_vec_t;
    typedef logic [NUM_STAT-1:0] stat_vec_t;

endpackage

// File: rtl/dev_err_pend_track.sv
module dev_err_pend_track
    import dev_err_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic             cpl,
    output logic [CNT_W-1:0] cnt,
    output logic             pending
);

    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_NEAR = CNT_MAX - CNT_ONE;

    pend_state_t st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic issue_only, cpl_only, do_inc, do_dec;

    assign issue_only = issue & ~cpl;
    assign cpl_only   = cpl & ~issue;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PEND_IDLE: begin
                if (issue_only) st_d = PEND_BUSY;
            end
            PEND_BUSY: begin
                if (cpl_only && cnt_q == CNT_ONE)        st_d = PEND_IDLE;
                else if (issue_only && cnt_q == CNT_NEAR) st_d = PEND_FULL;
            end
            PEND_FULL: begin
                if (cpl_only) st_d = PEND_BUSY;
            end
            default: st_d = PEND_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PEND_IDLE;
        else        st_q <= st_d;
    end

    // count guarded by the state: no increment when full, no decrement when idle
    assign do_inc = issue_only & (st_q != PEND_FULL);
    assign do_dec = cpl_only   & (st_q != PEND_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (do_inc) cnt_q <= cnt_q + CNT_ONE;
        else if (do_dec) cnt_q <= cnt_q - CNT_ONE;
    end

    // outputs
    always_comb begin
        pending = (st_q != PEND_IDLE);
        cnt     = cnt_q;
    end

endmodule

// File: rtl/dev_err_sticky.sv
module dev_err_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n)      bit_q <= 1'b0;
            else if (set[i]) bit_q <= 1'b1;   // a new event beats a clear
            else if (clr[i]) bit_q <= 1'b0;
        end
        assign q[i] = bit_q;
    end

endmodule

// File: rtl/dev_err_msg_gate.sv
module dev_err_msg_gate #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] en,
    input  logic [N-1:0] mask,
    output logic [N-1:0] msg
);

    for (genvar i = 0; i < N; i++) begin : g_cls
        logic req_q;
        always_ff @(posedge clk) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= evt[i] & en[i] & ~mask[i];
        end
        assign msg[i] = req_q;
    end

endmodule

// File: rtl/dev_err_regs.sv
module dev_err_regs
    import dev_err_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [1:0]        reg_be,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              err_corr,
    input  logic              err_nonfatal,
    input  logic              err_fatal,
    input  logic              ur_event,
    input  logic              ur_fwd,
    input  logic              mask_corr,
    input  logic              mask_nonfatal,
    input  logic              mask_fatal,
    input  logic              np_issue,
    input  logic              np_cpl,
    output logic              msg_corr,
    output logic              msg_nonfatal,
    output logic              msg_fatal
);

    logic ctrl_hit, stat_hit, ctrl_wr, stat_wr;
    cls_vec_t  ctrl_q, cls_evt, cls_mask, cls_msg;
    stat_vec_t stat_q, stat_set, stat_clr;
    logic [CNT_W-1:0] cnt_q;
    logic pending;
    logic unused_hi;

    // word decode, address bit 0 selects a byte and is not part of the decode
    assign ctrl_hit = (reg_addr[ADDR_W-1:1] == CTRL_OFS[ADDR_W-1:1]);
    assign stat_hit = (reg_addr[ADDR_W-1:1] == STAT_OFS[ADDR_W-1:1]);
    assign ctrl_wr  = reg_wr & ctrl_hit & reg_be[0];
    assign stat_wr  = reg_wr & stat_hit & reg_be[0];

    assign unused_hi = ^{reg_addr[0], reg_be[1], reg_wdata[REG_W-1:NUM_STAT]};

    // control word: three enables in the low byte
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= reg_wdata[NUM_CLS-1:0];
    end

    assign cls_evt  = {err_fatal, err_nonfatal, err_corr};
    assign cls_mask = {mask_fatal, mask_nonfatal, mask_corr};

    assign stat_set = {ur_event & ~ur_fwd, err_fatal, err_nonfatal, err_corr};
    assign stat_clr = stat_wr ? reg_wdata[NUM_STAT-1:0] : '0;

    dev_err_sticky #(.N(NUM_STAT)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (stat_set),
        .clr   (stat_clr),
        .q     (stat_q)
    );

    dev_err_msg_gate #(.N(NUM_CLS)) u_msg (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (cls_evt),
        .en    (ctrl_q),
        .mask  (cls_mask),
        .msg   (cls_msg)
    );

    dev_err_pend_track #(.CNT_W(CNT_W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (np_issue),
        .cpl     (np_cpl),
        .cnt     (cnt_q),
        .pending (pending)
    );

    assign msg_corr     = cls_msg[0];
    assign msg_nonfatal = cls_msg[1];
    assign msg_fatal    = cls_msg[2];

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (ctrl_hit) begin
            reg_rdata[NUM_CLS-1:0] = ctrl_q;
        end else if (stat_hit) begin
            reg_rdata[NUM_STAT-1:0] = stat_q;
            reg_rdata[STAT_AUX_BIT]  = 1'b0;
            reg_rdata[STAT_PEND_BIT] = pending;
        end
    end

endmodule

// File: rtl/dev_err_regs_chk.sv
module dev_err_regs_chk
    import dev_err_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [1:0]        reg_be,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              err_corr,
    input logic              err_fatal,
    input logic              ur_event,
    input logic              ur_fwd,
    input logic              mask_fatal,
    input logic              np_issue,
    input logic              np_cpl,
    input logic              msg_fatal,
    input logic [NUM_CLS-1:0]  ctrl_q,
    input logic [NUM_STAT-1:0] stat_q,
    input logic [CNT_W-1:0]    cnt_q
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic stat_sel;
    assign stat_sel = (reg_addr[ADDR_W-1:1] == STAT_OFS[ADDR_W-1:1]);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        stat_sel |-> (reg_rdata[15:6] == '0 && !reg_rdata[STAT_AUX_BIT]));                // R2

    AST_PEND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        stat_sel |-> (reg_rdata[STAT_PEND_BIT] == (cnt_q != '0)));                       // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CMAX && np_issue && !np_cpl) |=> (cnt_q == CMAX));                     // R4

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && np_cpl && !np_issue) |=> (cnt_q == '0));                         // R4

    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (np_issue && np_cpl) |=> $stable(cnt_q));                                        // R4

    AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        err_corr |=> stat_q[STAT_CE_BIT]);                                               // R5

    AST_UR_FWD_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_q[STAT_UR_BIT] && (!ur_event || ur_fwd)) |=> !stat_q[STAT_UR_BIT]);       // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_fatal && reg_wr && stat_sel && reg_be[0] && reg_wdata[STAT_FE_BIT])
            |=> stat_q[STAT_FE_BIT]);                                                    // R8

    AST_MSG_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        msg_fatal |-> $past(err_fatal && ctrl_q[2] && !mask_fatal));                     // R10

    AST_MSG_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        (err_fatal && ctrl_q[2] && !mask_fatal) |=> msg_fatal);                          // R10

endmodule

bind dev_err_regs dev_err_regs_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_be     (reg_be),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .err_corr   (err_corr),
    .err_fatal  (err_fatal),
    .ur_event   (ur_event),
    .ur_fwd     (ur_fwd),
    .mask_fatal (mask_fatal),
    .np_issue   (np_issue),
    .np_cpl     (np_cpl),
    .msg_fatal  (msg_fatal),
    .ctrl_q     (ctrl_q),
    .stat_q     (stat_q),
    .cnt_q      (cnt_q)
);

// File: tb/tb_dev_err_regs.sv
`timescale 1ns/1ps
module tb_dev_err_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [1:0]  reg_be = 2'b00;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        err_corr = 0, err_nonfatal = 0, err_fatal = 0;
    logic        ur_event = 0, ur_fwd = 0;
    logic        mask_corr = 0, mask_nonfatal = 0, mask_fatal = 0;
    logic        np_issue = 0, np_cpl = 0;
    logic        msg_corr, msg_nonfatal, msg_fatal;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model
    logic [2:0] m_ctrl = '0;
    logic [3:0] m_stat = '0;
    int         m_cnt = 0;
    logic [2:0] m_msg = '0;

    always #10 clk = ~clk;   // 50 MHz

    dev_err_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .err_corr(err_corr), .err_nonfatal(err_nonfatal), .err_fatal(err_fatal),
        .ur_event(ur_event), .ur_fwd(ur_fwd),
        .mask_corr(mask_corr), .mask_nonfatal(mask_nonfatal), .mask_fatal(mask_fatal),
        .np_issue(np_issue), .np_cpl(np_cpl),
        .msg_corr(msg_corr), .msg_nonfatal(msg_nonfatal), .msg_fatal(msg_fatal)
    );

    function automatic logic [15:0] exp_read(input logic [7:0] a);
        if (a[7:1] == 7'h26) return {13'h0, m_ctrl};
        if (a[7:1] == 7'h27) return {10'h0, (m_cnt != 0), 1'b0, m_stat};
        return 16'h0;
    endfunction

    function automatic int next_cnt(input int c, input logic iss, input logic cpl);
        if (iss && !cpl && c < 63) return c + 1;
        if (cpl && !iss && c > 0)  return c - 1;
        return c;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [7:0] a, input string tag);
        reg_wr = 1'b0;
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp_read(a));
    endtask

    // one clock cycle: drive at negedge, update model at the edge, check at next negedge
    task automatic cyc(input logic wr, input logic [7:0] a, input logic [1:0] be,
                       input logic [15:0] wd, input logic [2:0] evt, input logic ur,
                       input logic urf, input logic [2:0] msk, input logic iss,
                       input logic cpl, input string tag, input string mtag);
        logic [3:0] clr;
        logic [3:0] setv;
        logic [2:0] nctrl;
        reg_wr = wr; reg_addr = a; reg_be = be; reg_wdata = wd;
        {err_fatal, err_nonfatal, err_corr} = evt;
        ur_event = ur; ur_fwd = urf;
        {mask_fatal, mask_nonfatal, mask_corr} = msk;
        np_issue = iss; np_cpl = cpl;
        clr   = (wr && a[7:1] == 7'h27 && be[0]) ? wd[3:0] : 4'h0;
        setv  = {ur & ~urf, evt};
        nctrl = (wr && a[7:1] == 7'h26 && be[0]) ? wd[2:0] : m_ctrl;
        @(posedge clk);
        m_msg  = evt & m_ctrl & ~msk;
        m_stat = (m_stat & ~clr) | setv;
        m_ctrl = nctrl;
        m_cnt  = next_cnt(m_cnt, iss, cpl);
        @(negedge clk);
        chk(tag, reg_rdata, exp_read(a));
        chk(mtag, {13'h0, msg_fatal, msg_nonfatal, msg_corr}, {13'h0, m_msg});
    endtask

    task automatic idle(input logic [7:0] a, input string tag);
        cyc(0, a, 2'b00, 16'h0, 3'b000, 0, 0, 3'b000, 0, 0, tag, "R10");
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [1:0] be, input logic [15:0] wd,
                          input string tag);
        cyc(1, a, be, wd, 3'b000, 0, 0, 3'b000, 0, 0, tag, "R10");
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd7013);
        repeat (3) @(negedge clk);
        // R1: reset state
        peek(8'h4C, "R1");
        peek(8'h4E, "R1");
        rst_n = 1'b1;
        idle(8'h4E, "R1");

        // R9: control enables and byte enables
        wr_reg(8'h4C, 2'b11, 16'hFFFF, "R9");
        wr_reg(8'h4C, 2'b10, 16'h0000, "R9");
        wr_reg(8'h4C, 2'b01, 16'h0000, "R9");
        wr_reg(8'h4D, 2'b01, 16'h0005, "R9");
        peek(8'h4C, "R9");

        // R2: reserved and read-only bits, foreign address
        wr_reg(8'h4E, 2'b11, 16'hFFF0, "R2");
        wr_reg(8'h50, 2'b11, 16'hFFFF, "R2");
        peek(8'h4C, "R2");
        peek(8'h50, "R2");

        // R5: detected bits latch even when disabled or masked
        wr_reg(8'h4C, 2'b01, 16'h0000, "R9");
        cyc(0, 8'h4E, 2'b00, 16'h0, 3'b100, 0, 0, 3'b100, 0, 0, "R5", "R10");
        cyc(0, 8'h4E, 2'b00, 16'h0, 3'b010, 0, 0, 3'b000, 0, 0, "R5", "R10");
        cyc(0, 8'h4E, 2'b00, 16'h0, 3'b001, 0, 0, 3'b111, 0, 0, "R5", "R10");

        // R7: write-one-to-clear with byte enables
        wr_reg(8'h4E, 2'b10, 16'h0007, "R7");
        wr_reg(8'h4E, 2'b01, 16'h0000, "R7");
        wr_reg(8'h4E, 2'b01, 16'h0001, "R7");
        wr_reg(8'h4F, 2'b01, 16'h0002, "R7");

        // R8: set wins over a same-cycle clear
        cyc(1, 8'h4E, 2'b01, 16'h0004, 3'b100, 0, 0, 3'b000, 0, 0, "R8", "R10");
        cyc(1, 8'h4E, 2'b01, 16'h000F, 3'b001, 0, 0, 3'b000, 0, 0, "R8", "R10");
        wr_reg(8'h4E, 2'b01, 16'h000F, "R7");

        // R6: forwarded unsupported completions do not set bit 3
        cyc(0, 8'h4E, 2'b00, 16'h0, 3'b000, 1, 1, 3'b000, 0, 0, "R6", "R10");
        cyc(0, 8'h4E, 2'b00, 16'h0, 3'b000, 1, 0, 3'b000, 0, 0, "R6", "R10");
        cyc(1, 8'h4E, 2'b01, 16'h0008, 3'b000, 1, 1, 3'b000, 0, 0, "R6", "R10");

        // R10: message gating by enable and mask
        wr_reg(8'h4C, 2'b01, 16'h0007, "R9");
        cyc(0, 8'h4E, 2'b00, 16'h0, 3'b100, 0, 0, 3'b000, 0, 0, "R5", "R10");
        cyc(0, 8'h4E, 2'b00, 16'h0, 3'b010, 0, 0, 3'b010, 0, 0, "R5", "R10");
        cyc(0, 8'h4E, 2'b00, 16'h0, 3'b111, 0, 0, 3'b001, 0, 0, "R5", "R10");
        wr_reg(8'h4C, 2'b01, 16'h0002, "R9");
        cyc(0, 8'h4E, 2'b00, 16'h0, 3'b111, 0, 0, 3'b000, 0, 0, "R5", "R10");
        wr_reg(8'h4E, 2'b01, 16'h000F, "R7");

        // R3/R4: pending flag and counter corners
        cyc(0, 8'h4E, 2'b00, 16'h0, 3'b000, 0, 0, 3'b000, 1, 0, "R3", "R10");
        cyc(0, 8'h4E, 2'b00, 16'h0, 3'b000, 0, 0, 3'b000, 0, 1, "R3", "R10");
        cyc(0, 8'h4E, 2'b00, 16'h0, 3'b000, 0, 0, 3'b000, 0, 1, "R4", "R10");
        cyc(0, 8'h4E, 2'b00, 16'h0, 3'b000, 0, 0, 3'b000, 1, 1, "R4", "R10");
        cyc(0, 8'h4E, 2'b00, 16'h0, 3'b000, 0, 0, 3'b000, 1, 0, "R4", "R10");
        cyc(0, 8'h4E, 2'b00, 16'h0, 3'b000, 0, 0, 3'b000, 0, 1, "R4", "R10");
        for (int i = 0; i < 70; i++)
            cyc(0, 8'h4E, 2'b00, 16'h0, 3'b000, 0, 0, 3'b000, 1, 0, "R4", "R10");
        cyc(0, 8'h4E, 2'b00, 16'h0, 3'b000, 0, 0, 3'b000, 1, 1, "R4", "R10");
        for (int i = 0; i < 64; i++)
            cyc(0, 8'h4E, 2'b00, 16'h0, 3'b000, 0, 0, 3'b000, 0, 1, "R4", "R10");

        // seeded random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a;
            logic [2:0] evt;
            logic [2:0] msk;
            int sel;
            string t;
            sel = $urandom_range(0, 4);
            a = (sel == 0) ? 8'h4C : (sel == 1) ? 8'h4F :
                (sel == 4) ? 8'($urandom) : 8'h4E;
            evt = {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
                   ($urandom_range(0, 7) == 0)};
            msk = 3'($urandom);
            t = (a[7:1] == 7'h26) ? "R9" : (a[7:1] == 7'h27) ? "R3" : "R2";
            cyc(($urandom_range(0, 3) == 0), a, 2'($urandom), 16'($urandom), evt,
                ($urandom_range(0, 5) == 0), 1'($urandom),
                msk, ($urandom_range(0, 99) < ((i / 500) % 2 == 0 ? 70 : 35)),
                ($urandom_range(0, 99) < 50), t, "R10");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule